// File: doc/BRIEF.md
# Board Control and Status Register with Watchdog and Bus Timer

This block holds one byte of board-level control and status. Software reaches it through a single-offset synchronous register port. It enables a green front-panel LED, arms a watchdog that can only be switched on and never off, and enables an on-board bus cycle timer. Sticky flags show which timeout happened. The flags cover a watchdog expiry, an on-board bus timeout and a timeout reported by an external bus monitor. A fourth flag latches the power-fail line.

The watchdog runs a count derived from the clock frequency, nominally 512 ms. Each write of 1 to the trigger bit restarts it. When the count runs out, the block raises a reset request and holds it until the system reset arrives. The expiry flag sits on the power-on/push-button reset alone, so it survives the reset that the watchdog itself requested, and boot code can tell a watchdog restart from a button press.

The bus timer times every on-board cycle while the cycle-in-progress strobe is high, and that includes any wait from a bus request to its grant. If a cycle lasts a derived count, nominally 8 µs, the timer raises a bus error and keeps it up until the cycle ends.

Watchdog states:
- WD_OFF moves to WD_RUN once the enable bit is 1.
- WD_RUN restarts on a trigger.
- WD_RUN moves to WD_FIRE when the terminal count is reached.
- WD_FIRE is left only by reset.

Bus timer states:
- BT_IDLE moves to BT_TIME when a cycle starts while the timer is enabled.
- BT_TIME returns to BT_IDLE when the cycle ends or the timer is disabled.
- BT_TIME moves to BT_ERR when the terminal count is reached.
- BT_ERR returns to BT_IDLE when the cycle ends.

Top module: `board_ctl_stat`

## Requirements
- R1: After a power-on reset (`por_n` low for at least one clock), `reg_rdata` reads 0x00 and `wdog_rst_req`, `bus_err` and `led_green` are all 0.
- R2: Bit layout of `reg_rdata`, MSB first:
  - bit7 is the watchdog-expired flag.
  - bit6 is the external bus-monitor flag.
  - bit5 is the on-board bus timer flag.
  - bit4 is the watchdog enable.
  - bit3 is the trigger, which always reads 0.
  - bit2 is the bus timer enable.
  - bit1 is the latched power-fail flag.
  - bit0 is the LED enable.
  
  Bits 2 and 0 are plain read/write, and `led_green` follows bit0.
- R3: Writing 1 to bit4 sets the watchdog enable. A later write of 0 to bit4 leaves it at 1, and only a reset clears it.
- R4: With the watchdog running, `wdog_rst_req` rises exactly WD_TERM clock edges after the edge that takes a trigger write, where WD_TERM = CLK_HZ*WD_MS/1000. Every new trigger restarts the full count.
- R5: Triggers written while bit4 is 0 have no effect, and `wdog_rst_req` stays 0. Once raised, `wdog_rst_req` stays 1, even through further triggers, until `sys_rst_n` or `por_n` goes low.
- R6: Watchdog expiry sets bit7 on the same edge that raises `wdog_rst_req`. Bit7 keeps its value through `sys_rst_n` and is cleared by `por_n`.
- R7: With bit2 set, a cycle whose strobe `cyc_active` stays high raises `bus_err` on the BT_TERM-th edge after the first edge that sees the strobe, where BT_TERM = CLK_HZ*BT_US/1e6. The same edge sets bit5. `bus_err` falls one edge after the strobe drops.
- R8: A cycle that ends after at most BT_TERM edges, or any cycle while bit2 is 0, raises neither `bus_err` nor bit5.
- R9: A one-cycle pulse on `ext_bto` sets bit6 and does not raise `bus_err`.
- R10: While `pwr_fail` is high, bit1 is set, and it stays set after `pwr_fail` returns low.
- R11: Bits 7, 6, 5 and 1 are cleared by writing 0 to them. Writing 1 to them neither sets nor clears them. When a set event and a clearing write meet on the same edge, the set wins.
- R12: `sys_rst_n` low clears every bit except bit7, drops `wdog_rst_req` and returns both state machines to their idle states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on / push-button reset, active low, synchronous; clears everything |
| sys_rst_n | input | 1 | System reset (includes watchdog-requested reset), active low, synchronous; keeps bit7 |
| reg_wr | input | 1 | Write strobe for the register byte |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Current register value (combinational read) |
| cyc_active | input | 1 | High while an on-board I/O cycle, including request-to-grant, is in progress |
| ext_bto | input | 1 | Timeout pulse from the external bus monitor |
| pwr_fail | input | 1 | Power-fail line, active high |
| wdog_rst_req | output | 1 | Reset request raised on watchdog expiry |
| bus_err | output | 1 | Bus error from the on-board bus timer |
| led_green | output | 1 | Green LED drive |

## Verification
The bench measures the watchdog interval from the last trigger down to the exact edge. A design that ignored triggers, or that counted one edge early or late, would raise the reset request at the wrong sample. It then drives the system reset while the request is active. A design that placed the expiry flag on the combined reset would lose the reset cause, and one that kept the watchdog armed would keep requesting reset.

A bus cycle held exactly BT_TERM edges must pass without error, and one edge longer must fail. An off-by-one timer fails one side of that pair. Flag clearing is tried with writes of 1 and with a write of 0 that meets a live power-fail level. A design that lets writes set flags, or lets the clear beat the set, reads back the wrong byte.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    // Bit positions inside the control/status byte
    localparam int B_WDF = 7;   // watchdog expired (sticky)
    localparam int B_EXF = 6;   // external bus monitor timeout (sticky)
    localparam int B_BTF = 5;   // on-board bus timer timeout (sticky)
    localparam int B_WDE = 4;   // watchdog enable (set-once)
    localparam int B_TRG = 3;   // watchdog trigger (reads 0)
    localparam int B_BTE = 2;   // bus timer enable
    localparam int B_PWF = 1;   // latched power fail (sticky)
    localparam int B_LED = 0;   // LED enable

    localparam int REG_W = 8;

    typedef enum logic [1:0] {
        WD_OFF  = 2'd0,
        WD_RUN  = 2'd1,
        WD_FIRE = 2'd2
    } wd_state_e;

    typedef enum logic [1:0] {
        BT_IDLE = 2'd0,
        BT_TIME = 2'd1,
        BT_ERR  = 2'd2
    } bt_state_e;

    // Cycles for a duration of 'amount' units where 'per_sec' units make a second.
    function automatic int unsigned cycles_for(input longint unsigned hz,
                                               input longint unsigned amount,
                                               input longint unsigned per_sec);
        longint unsigned c;
        c = (hz * amount) / per_sec;
        if (c < 2) c = 2;
        return int'(c);
    endfunction

endpackage

// File: rtl/bcs_watchdog.sv
module bcs_watchdog
    import bcs_pkg::*;
#(
    parameter int unsigned TERM = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic kick,
    output logic expire,
    output logic rst_req
);
    localparam int CW = $clog2(TERM) + 1;
    localparam logic [CW-1:0] LAST = CW'(TERM - 1);

    wd_state_e      state_q, state_d;
    logic [CW-1:0]  cnt_q, cnt_d;
    logic           at_last;

    assign at_last = (cnt_q == LAST);

    // next-state and counter logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            WD_OFF: begin
                cnt_d = '0;
                if (enable) state_d = WD_RUN;
            end
            WD_RUN: begin
                if (kick) begin
                    cnt_d = '0;
                end else if (at_last) begin
                    state_d = WD_FIRE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            WD_FIRE: begin
                cnt_d = '0;
            end
            default: begin
                state_d = WD_OFF;
                cnt_d   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WD_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        expire  = 1'b0;
        rst_req = 1'b0;
        unique case (state_q)
            WD_OFF:  ;
            WD_RUN:  expire  = at_last && !kick;
            WD_FIRE: rst_req = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/bcs_bus_timer.sv
module bcs_bus_timer
    import bcs_pkg::*;
#(
    parameter int unsigned TERM = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic cyc_active,
    output logic timeout,
    output logic bus_err
);
    localparam int CW = $clog2(TERM) + 1;
    localparam logic [CW-1:0] LAST = CW'(TERM - 1);

    bt_state_e      state_q, state_d;
    logic [CW-1:0]  cnt_q, cnt_d;
    logic           live;

    assign live = enable && cyc_active;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            BT_IDLE: begin
                cnt_d = '0;
                if (live) state_d = BT_TIME;
            end
            BT_TIME: begin
                if (!live) begin
                    state_d = BT_IDLE;
                    cnt_d   = '0;
                end else if (cnt_q == LAST) begin
                    state_d = BT_ERR;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            BT_ERR: begin
                cnt_d = '0;
                if (!cyc_active) state_d = BT_IDLE;
            end
            default: begin
                state_d = BT_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BT_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        timeout = 1'b0;
        bus_err = 1'b0;
        unique case (state_q)
            BT_IDLE: ;
            BT_TIME: timeout = live && (cnt_q == LAST);
            BT_ERR:  bus_err = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/bcs_regbank.sv
module bcs_regbank
    import bcs_pkg::*;
(
    input  logic             clk,
    input  logic             por_n,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    input  logic             wd_expire,
    input  logic             bt_timeout,
    input  logic             ext_bto,
    input  logic             pwr_fail,
    output logic [REG_W-1:0] rdata,
    output logic             wd_en,
    output logic             bt_en,
    output logic             led,
    output logic             kick
);
    localparam int NFLG = 3;

    logic            wdf_q;
    logic            wde_q;
    logic            bte_q;
    logic            led_q;
    logic [NFLG-1:0] flg_q;
    logic [NFLG-1:0] flg_set;

    // flag slot 2: external monitor, slot 1: bus timer, slot 0: power fail
    assign flg_set = {ext_bto, bt_timeout, pwr_fail};

    // expiry flag lives only on the power-on reset
    always_ff @(posedge clk) begin
        if (!por_n)                      wdf_q <= 1'b0;
        else if (wd_expire)              wdf_q <= 1'b1;
        else if (wr && !wdata[B_WDF])    wdf_q <= 1'b0;
    end

    // sticky flags on the combined reset; set beats clear
    for (genvar g = 0; g < NFLG; g++) begin : g_flag
        localparam int POS = (g == 2) ? B_EXF : (g == 1) ? B_BTF : B_PWF;
        always_ff @(posedge clk) begin
            if (!rst_n)                   flg_q[g] <= 1'b0;
            else if (flg_set[g])          flg_q[g] <= 1'b1;
            else if (wr && !wdata[POS])   flg_q[g] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wde_q <= 1'b0;
            bte_q <= 1'b0;
            led_q <= 1'b0;
        end else if (wr) begin
            wde_q <= wde_q | wdata[B_WDE];
            bte_q <= wdata[B_BTE];
            led_q <= wdata[B_LED];
        end
    end

    always_comb begin
        rdata        = '0;
        rdata[B_WDF] = wdf_q;
        rdata[B_EXF] = flg_q[2];
        rdata[B_BTF] = flg_q[1];
        rdata[B_WDE] = wde_q;
        rdata[B_TRG] = 1'b0;
        rdata[B_BTE] = bte_q;
        rdata[B_PWF] = flg_q[0];
        rdata[B_LED] = led_q;
    end

    assign wd_en = wde_q;
    assign bt_en = bte_q;
    assign led   = led_q;
    assign kick  = wr && wdata[B_TRG];

endmodule

// File: rtl/board_ctl_stat.sv
module board_ctl_stat
    import bcs_pkg::*;
#(
    parameter int unsigned CLK_HZ = 50_000_000,
    parameter int unsigned WD_MS  = 512,
    parameter int unsigned BT_US  = 8
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       sys_rst_n,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       cyc_active,
    input  logic       ext_bto,
    input  logic       pwr_fail,
    output logic       wdog_rst_req,
    output logic       bus_err,
    output logic       led_green
);
    localparam int unsigned WD_TERM = cycles_for(CLK_HZ, WD_MS, 1000);
    localparam int unsigned BT_TERM = cycles_for(CLK_HZ, BT_US, 1_000_000);

    logic rst_n;
    logic wd_en, bt_en, kick;
    logic wd_expire, bt_timeout;

    assign rst_n = por_n && sys_rst_n;

    bcs_regbank u_regs (
        .clk        (clk),
        .por_n      (por_n),
        .rst_n      (rst_n),
        .wr         (reg_wr),
        .wdata      (reg_wdata),
        .wd_expire  (wd_expire),
        .bt_timeout (bt_timeout),
        .ext_bto    (ext_bto),
        .pwr_fail   (pwr_fail),
        .rdata      (reg_rdata),
        .wd_en      (wd_en),
        .bt_en      (bt_en),
        .led        (led_green),
        .kick       (kick)
    );

    bcs_watchdog #(.TERM(WD_TERM)) u_wdog (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (wd_en),
        .kick    (kick),
        .expire  (wd_expire),
        .rst_req (wdog_rst_req)
    );

    bcs_bus_timer #(.TERM(BT_TERM)) u_btmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (bt_en),
        .cyc_active (cyc_active),
        .timeout    (bt_timeout),
        .bus_err    (bus_err)
    );

endmodule

// File: rtl/board_ctl_stat_chk.sv
module board_ctl_stat_chk (
    input logic       clk,
    input logic       por_n,
    input logic       sys_rst_n,
    input logic       reg_wr,
    input logic [7:0] reg_wdata,
    input logic [7:0] reg_rdata,
    input logic       cyc_active,
    input logic       ext_bto,
    input logic       pwr_fail,
    input logic       wdog_rst_req,
    input logic       bus_err
);
    logic any_rst;
    assign any_rst = !(por_n && sys_rst_n);

    p_wden_sticky_r3: assert property (@(posedge clk) disable iff (any_rst)
        reg_rdata[4] |=> reg_rdata[4]);

    p_rstreq_hold_r5: assert property (@(posedge clk) disable iff (any_rst)
        wdog_rst_req |=> wdog_rst_req);

    p_off_no_req_r5: assert property (@(posedge clk) disable iff (any_rst)
        !reg_rdata[4] |-> !wdog_rst_req);

    p_wdflag_on_fire_r6: assert property (@(posedge clk) disable iff (any_rst)
        $rose(wdog_rst_req) |-> reg_rdata[7]);

    p_wdflag_kept_r6: assert property (@(posedge clk) disable iff (!por_n)
        (reg_rdata[7] && !(reg_wr && !reg_wdata[7])) |=> reg_rdata[7]);

    p_busflag_r7: assert property (@(posedge clk) disable iff (any_rst)
        $rose(bus_err) |-> reg_rdata[5]);

    p_bus_drop_r7: assert property (@(posedge clk) disable iff (any_rst)
        (bus_err && !cyc_active) |=> !bus_err);

    p_ext_flag_r9: assert property (@(posedge clk) disable iff (any_rst)
        ext_bto |=> reg_rdata[6]);

    p_pf_latch_r10: assert property (@(posedge clk) disable iff (any_rst)
        pwr_fail |=> reg_rdata[1]);

endmodule

bind board_ctl_stat board_ctl_stat_chk u_chk (
    .clk          (clk),
    .por_n        (por_n),
    .sys_rst_n    (sys_rst_n),
    .reg_wr       (reg_wr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .cyc_active   (cyc_active),
    .ext_bto      (ext_bto),
    .pwr_fail     (pwr_fail),
    .wdog_rst_req (wdog_rst_req),
    .bus_err      (bus_err)
);

// File: tb/board_ctl_stat_bench.sv
`timescale 1ns/1ps
module board_ctl_stat_bench;
    localparam int unsigned CLK_HZ = 1_000_000;
    localparam int unsigned WD_MS  = 2;
    localparam int unsigned BT_US  = 8;
    localparam int WDT = 2000;   // CLK_HZ*WD_MS/1000
    localparam int BTT = 8;      // CLK_HZ*BT_US/1e6

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       sys_rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       cyc_active = 1'b0;
    logic       ext_bto = 1'b0;
    logic       pwr_fail = 1'b0;
    logic       wdog_rst_req;
    logic       bus_err;
    logic       led_green;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    board_ctl_stat #(.CLK_HZ(CLK_HZ), .WD_MS(WD_MS), .BT_US(BT_US)) u_board_ctl_stat (
        .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cyc_active(cyc_active), .ext_bto(ext_bto), .pwr_fail(pwr_fail),
        .wdog_rst_req(wdog_rst_req), .bus_err(bus_err), .led_green(led_green)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_write(input logic [7:0] d);
        reg_wr = 1'b1;
        reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic t_reset;
        por_n = 1'b0; sys_rst_n = 1'b1;
        wait_edges(3);
        por_n = 1'b1;
        wait_edges(1);
        check("R1 rdata", reg_rdata, 8'h00);
        check("R1 outputs", {5'b0, wdog_rst_req, bus_err, led_green}, 8'h00);
    endtask

    task automatic t_layout;
        do_write(8'h05);
        check("R2 rw bits", reg_rdata, 8'h05);
        check("R2 led", {7'b0, led_green}, 8'h01);
        do_write(8'h0D);
        check("R2 trigger reads 0", reg_rdata, 8'h05);
        do_write(8'h04);
        check("R2 led off", {7'b0, led_green}, 8'h00);
    endtask

    task automatic t_flags;
        do_write(8'hE2);
        check("R11 write 1 does not set", reg_rdata, 8'h00);
        pwr_fail = 1'b1;
        wait_edges(1);
        pwr_fail = 1'b0;
        wait_edges(2);
        check("R10 power fail latched", reg_rdata, 8'h02);
        ext_bto = 1'b1;
        wait_edges(1);
        ext_bto = 1'b0;
        check("R9 ext flag", reg_rdata, 8'h42);
        check("R9 no bus_err", {7'b0, bus_err}, 8'h00);
        do_write(8'h40);
        check("R11 clear by 0 keep by 1", reg_rdata, 8'h40);
        pwr_fail = 1'b1;
        do_write(8'h00);
        check("R11 set wins over clear", reg_rdata, 8'h02);
        pwr_fail = 1'b0;
        do_write(8'h00);
        check("R11 clear after set", reg_rdata, 8'h00);
    endtask

    task automatic t_bus;
        int seen;
        do_write(8'h04);
        // exactly BTT edges: no error (R8)
        seen = 0;
        cyc_active = 1'b1;
        for (int i = 0; i < BTT; i++) begin
            wait_edges(1);
            if (bus_err) seen++;
        end
        cyc_active = 1'b0;
        wait_edges(2);
        check("R8 boundary cycle no error", {7'b0, bus_err}, 8'h00);
        check("R8 boundary cycle count", 8'(seen), 8'h00);
        check("R8 no bit5", reg_rdata, 8'h04);
        // long cycle
        cyc_active = 1'b1;
        wait_edges(BTT);
        check("R7 not yet", {7'b0, bus_err}, 8'h00);
        wait_edges(1);
        check("R7 bus_err at term", {7'b0, bus_err}, 8'h01);
        check("R7 bit5 set", reg_rdata, 8'h24);
        wait_edges(3);
        check("R7 held", {7'b0, bus_err}, 8'h01);
        cyc_active = 1'b0;
        wait_edges(1);
        check("R7 drops", {7'b0, bus_err}, 8'h00);
        // disabled timer
        do_write(8'h20);
        cyc_active = 1'b1;
        seen = 0;
        for (int i = 0; i < BTT + 4; i++) begin
            wait_edges(1);
            if (bus_err) seen++;
        end
        cyc_active = 1'b0;
        wait_edges(1);
        check("R8 disabled no error", 8'(seen), 8'h00);
        check("R8 disabled flags", reg_rdata, 8'h20);
    endtask

    task automatic t_trig_off;
        do_write(8'h08);
        wait_edges(WDT + 5);
        check("R5 trigger while off", {7'b0, wdog_rst_req}, 8'h00);
        check("R5 rdata while off", reg_rdata, 8'h00);
    endtask

    task automatic t_watchdog;
        do_write(8'h10);
        do_write(8'h00);
        check("R3 enable set-once", reg_rdata, 8'h10);
        do_write(8'h08);
        wait_edges(WDT - 10);
        check("R4 before first term", {7'b0, wdog_rst_req}, 8'h00);
        do_write(8'h08);
        wait_edges(WDT - 1);
        check("R4 restarted count", {7'b0, wdog_rst_req}, 8'h00);
        wait_edges(1);
        check("R4 expire at term", {7'b0, wdog_rst_req}, 8'h01);
        check("R6 bit7 on expire", reg_rdata, 8'h90);
        do_write(8'h88);
        wait_edges(10);
        check("R5 request held", {7'b0, wdog_rst_req}, 8'h01);
        do_write(8'h81);
        ext_bto = 1'b1;
        wait_edges(1);
        ext_bto = 1'b0;
        check("R12 before sys reset", reg_rdata, 8'hD1);
        sys_rst_n = 1'b0;
        wait_edges(2);
        sys_rst_n = 1'b1;
        wait_edges(1);
        check("R12 sys reset keeps bit7", reg_rdata, 8'h80);
        check("R12 request dropped", {7'b0, wdog_rst_req}, 8'h00);
        wait_edges(WDT + 5);
        check("R12 watchdog idle after reset", {7'b0, wdog_rst_req}, 8'h00);
        por_n = 1'b0;
        wait_edges(2);
        por_n = 1'b1;
        wait_edges(1);
        check("R6 por clears bit7", reg_rdata, 8'h00);
    endtask

    initial begin
        t_reset();
        t_layout();
        t_flags();
        t_bus();
        t_trig_off();
        t_watchdog();
        done = 1'b1;
    end

    initial begin
        fork
            begin wait (done); end
            begin
                repeat (100_000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule